// File: doc/BRIEF.md
# Forwarding Register File

A register file with one write port and two combinational read ports. A write that is active in a cycle is stored in the array at the next rising clock edge. In the same cycle it is also forwarded to any read port whose address matches. A read in that cycle therefore already sees the new value, as if the write had happened first. A read of a different register in the same cycle returns the stored contents and is not affected by the write in any way.

A read port has no handshake. Its data is a pure function of the current addresses, the write inputs and the array contents, so no valid/ready flow applies and back-pressure cannot occur. A parameter can pin register 0 to zero. In that mode writes to register 0 are discarded and are never forwarded. By default the option is off and every register is writable. Reset clears all contents to zero.

Top module: `byprf_top`

## Requirements
- R1: While reset is held and after it is released, every register reads as zero on both ports until it is written.
- R2: When `wr_en` is 1 at a rising edge, `wr_data` is stored in register `wr_addr` and is returned by later reads of that register.
- R3: When `wr_en` is 1 and `rd_a_addr` equals `wr_addr`, `rd_a_data` returns `wr_data` in the same cycle.
- R4: When `wr_en` is 1 and `rd_b_addr` equals `wr_addr`, `rd_b_data` returns `wr_data` in the same cycle. This comparison is independent of port A.
- R5: When `wr_en` is 0, a read returns the stored value, even if its address equals `wr_addr`.
- R6: When a read address differs from `wr_addr`, that port returns the stored value, and the write still commits.
- R7: Two ports given the same address return identical data, including when both are forwarded.
- R8: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_data` and `wr_addr` carry.
- R9: With `PIN_ZERO` = 1, register 0 always reads zero, and a write to it is neither stored nor forwarded. With `PIN_ZERO` = 0 (the default), register 0 behaves like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset, clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | $clog2(NUM_REGS) | Register written |
| wr_data | input | DATA_W | Value written and forwarded |
| rd_a_addr | input | $clog2(NUM_REGS) | Read port A register |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_addr | input | $clog2(NUM_REGS) | Read port B register |
| rd_b_data | output | DATA_W | Read port B data, combinational |

## Verification
Read data is due in the same cycle as the addresses and write inputs that produce it, forwarded values included. A committed write becomes visible one rising edge later. The bench drives every input at the falling edge and samples both ports 1 ns later, ahead of the next rising edge, so each sample reflects exactly one cycle's inputs and the array state left by the previous edge. Its reference model is updated only after the expectations for a cycle have been queued, which keeps same-cycle forwarding apart from the committed state.

// File: rtl/byprf_pkg.sv
`timescale 1ns/1ps
package byprf_pkg;
  localparam int unsigned BYPRF_DEF_REGS  = 32;
  localparam int unsigned BYPRF_DEF_WIDTH = 32;
  localparam int unsigned BYPRF_RD_PORTS  = 2;
endpackage

// File: rtl/byprf_wr_gate.sv
`timescale 1ns/1ps
module byprf_wr_gate #(
  parameter int unsigned AW       = 5,
  parameter bit          PIN_ZERO = 1'b0
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          commit_en
);
  logic pinned_target;

  generate
    if (PIN_ZERO) begin : g_pin
      assign pinned_target = (wr_addr == '0);
    end else begin : g_free
      assign pinned_target = 1'b0;
    end
  endgenerate

  assign commit_en = wr_en && !pinned_target;
endmodule

// File: rtl/byprf_store.sv
`timescale 1ns/1ps
module byprf_store #(
  parameter int unsigned NREG     = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 5,
  parameter bit          PIN_ZERO = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            wa,
  input  logic [DW-1:0]            wd,
  output logic [NREG-1:0][DW-1:0]  mem_q
);
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (PIN_ZERO && i == 0) begin : g_tied
        always_ff @(posedge clk) begin
          mem_q[i] <= '0;
        end
        // R9
        pinned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
          mem_q[i] == '0);
      end else begin : g_live
        always_ff @(posedge clk) begin
          if (!rst_n)                      mem_q[i] <= '0;
          else if (we && wa == AW'(i))     mem_q[i] <= wd;
        end
      end
    end
  endgenerate

  // R2
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(wa)] == $past(wd));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_q));
endmodule

// File: rtl/byprf_rd_port.sv
`timescale 1ns/1ps
module byprf_rd_port #(
  parameter int unsigned NREG     = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 5,
  parameter bit          PIN_ZERO = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     fwd_en,
  input  logic [AW-1:0]            fwd_addr,
  input  logic [DW-1:0]            fwd_data,
  input  logic [NREG-1:0][DW-1:0]  mem_q,
  output logic [DW-1:0]            rd_data
);
  logic          hit;
  logic [DW-1:0] stored;

  assign hit = fwd_en && (fwd_addr == rd_addr);

  generate
    if (PIN_ZERO) begin : g_pin
      assign stored = (rd_addr == '0) ? '0 : mem_q[rd_addr];
    end else begin : g_free
      assign stored = mem_q[rd_addr];
    end
  endgenerate

  assign rd_data = hit ? fwd_data : stored;

  // R3 R4
  fwd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && fwd_addr == rd_addr) |-> rd_data == fwd_data);

  // R6
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_en && fwd_addr == rd_addr) |-> rd_data == mem_q[rd_addr]);
endmodule

// File: rtl/byprf_top.sv
`timescale 1ns/1ps
module byprf_top #(
  parameter int unsigned NUM_REGS = byprf_pkg::BYPRF_DEF_REGS,
  parameter int unsigned DATA_W   = byprf_pkg::BYPRF_DEF_WIDTH,
  parameter bit          PIN_ZERO = 1'b0,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int unsigned NRD = byprf_pkg::BYPRF_RD_PORTS;

  logic                          commit_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
  logic [NRD-1:0][AW-1:0]        rd_addr_v;
  logic [NRD-1:0][DATA_W-1:0]    rd_data_v;

  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;
  assign rd_a_data    = rd_data_v[0];
  assign rd_b_data    = rd_data_v[1];

  byprf_wr_gate #(.AW(AW), .PIN_ZERO(PIN_ZERO)) u_gate (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .commit_en (commit_en)
  );

  byprf_store #(.NREG(NUM_REGS), .DW(DATA_W), .AW(AW), .PIN_ZERO(PIN_ZERO)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_en),
    .wa    (wr_addr),
    .wd    (wr_data),
    .mem_q (mem_q)
  );

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_port
      byprf_rd_port #(.NREG(NUM_REGS), .DW(DATA_W), .AW(AW), .PIN_ZERO(PIN_ZERO)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr_v[p]),
        .fwd_en   (commit_en),
        .fwd_addr (wr_addr),
        .fwd_data (wr_data),
        .mem_q    (mem_q),
        .rd_data  (rd_data_v[p])
      );
    end
  endgenerate

  // R7
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> rd_a_data == rd_b_data);
endmodule

// File: tb/byprf_top_tb_top.sv
`timescale 1ns/1ps
module byprf_top_tb_top;
  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_addr = '0;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] m_a, m_b, z_a, z_b;

  sb_item_t    sb[$];
  logic [31:0] model_m [32];
  logic [31:0] model_z [32];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  byprf_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(m_a), .rd_b_addr(rd_b_addr), .rd_b_data(m_b)
  );

  byprf_top #(.PIN_ZERO(1'b1)) dut_z (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(z_a), .rd_b_addr(rd_b_addr), .rd_b_data(z_b)
  );

  function automatic logic [31:0] exp_m(logic we, logic [4:0] wa, logic [31:0] wd, logic [4:0] ra);
    return (we && wa == ra) ? wd : model_m[ra];
  endfunction

  function automatic logic [31:0] exp_z(logic we, logic [4:0] wa, logic [31:0] wd, logic [4:0] ra);
    if (ra == 5'd0) return 32'd0;
    return (we && wa == ra) ? wd : model_z[ra];
  endfunction

  task automatic push(string req, int sel, logic [31:0] exp);
    sb_item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic cyc(logic we, logic [4:0] wa, logic [31:0] wd,
                     logic [4:0] ra, logic [4:0] rb, string req);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
    push(req, 0, exp_m(we, wa, wd, ra));
    push(req, 1, exp_m(we, wa, wd, rb));
    push(req, 2, exp_z(we, wa, wd, ra));
    push(req, 3, exp_z(we, wa, wd, rb));
    if (we) model_m[wa] = wd;
    if (we && wa != 5'd0) model_z[wa] = wd;
  endtask

  function automatic logic [31:0] pat(int r, int k);
    return 32'h9E3779B9 * 32'(r + 1) + 32'(k * 32'h01010101);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Monitor: compare queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        sb_item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        case (it.sel)
          0: got = m_a;
          1: got = m_b;
          2: got = z_a;
          default: got = z_b;
        endcase
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s port=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin model_m[r] = '0; model_z[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: everything reads zero after reset
    for (int r = 0; r < 32; r++) cyc(1'b0, 5'(r), 32'hFFFF_FFFF, 5'(r), 5'(31 - r), "R1");
    // R6: writes to every register, reads elsewhere; R2 covered by later reads
    for (int r = 0; r < 32; r++) cyc(1'b1, 5'(r), pat(r, 0), 5'((r + 5) % 32), 5'((r + 9) % 32), "R6");
    // R5: write disabled, address matches, junk data
    for (int r = 0; r < 32; r++) cyc(1'b0, 5'(r), 32'hDEAD_BEEF, 5'(r), 5'((r + 1) % 32), "R5");
    // R2: read back committed values
    for (int r = 0; r < 32; r++) cyc(1'b0, 5'((r + 3) % 32), pat(r, 7), 5'((r + 16) % 32), 5'(r), "R2");
    // R3: forwarding on port A
    for (int r = 0; r < 32; r += 3) cyc(1'b1, 5'(r), pat(r, 1), 5'(r), 5'((r + 3) % 32), "R3");
    // R4: forwarding on port B
    for (int r = 1; r < 32; r += 3) cyc(1'b1, 5'(r), pat(r, 2), 5'((r + 7) % 32), 5'(r), "R4");
    // R7: both ports same address, forwarded and not
    for (int r = 0; r < 32; r += 4) begin
      cyc(1'b1, 5'(r), pat(r, 3), 5'(r), 5'(r), "R7");
      cyc(1'b0, 5'(r), pat(r, 4), 5'(r), 5'(r), "R7");
    end
    // R8: idle cycles with changing junk, then full readback
    for (int r = 0; r < 8; r++) cyc(1'b0, 5'(r * 4), pat(r, 9), 5'(r), 5'(r + 8), "R8");
    for (int r = 0; r < 32; r += 2) cyc(1'b0, 5'(r), 32'h0, 5'(r), 5'(r + 1), "R8");
    // R9: register 0 pinned in one instance, writable in the default one
    cyc(1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd0, "R9");
    cyc(1'b0, 5'd0, 32'h0, 5'd0, 5'd1, "R9");
    cyc(1'b1, 5'd0, 32'hCAFE_F00D, 5'd1, 5'd0, "R9");
    cyc(1'b0, 5'd2, 32'h0, 5'd0, 5'd0, "R9");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    summary();
    $finish;
  end
endmodule